// File: doc/BRIEF.md
# Half-Duty Programmable Clock Divider

This block derives a slower clock from `clk_in`. The ratio is set at run time by an 8-bit unsigned value N on `prescale`. The output period is D = 1 + N input periods. The output stays high for exactly half of every output period, and this holds for odd D as well as even D. Two toggle registers make this possible. One is clocked on the rising edge of `clk_in` and the other on the falling edge, and the output is their XOR. For odd D this lets the falling edge of the output land in the middle of an input cycle. When N is 0 the block switches to a bypass path and the input clock passes straight through.

A new value on `prescale` is picked up only at the start of an output period, so a change never cuts a period short. The bypass select also changes only at points where no short pulse can appear. For logic that needs only the edge event, `rise_strobe` marks each output rising edge as a one-cycle pulse in the `clk_in` domain.

Top module: `hdd_divider`

## Requirements
- R1: While `rst_n` is low, `clk_out` and `rise_strobe` are low. After release, the first rising edge of `clk_out` falls on the first rising edge of `clk_in`.
- R2: With N = `prescale` in 1..255 (unsigned), the period of `clk_out` is exactly 1 + N periods of `clk_in`.
- R3: For an even ratio D = 1 + N, `clk_out` is high for exactly D/2 input periods, with both edges on rising edges of `clk_in`.
- R4: For an odd ratio D ≥ 3, `clk_out` is high for exactly D/2 input periods. Its falling edge is on the falling edge of `clk_in` in input cycle (D-1)/2 of the output period.
- R5: With N = 0, `clk_out` follows `clk_in` (period one input period, high for half of it).
- R6: `prescale` is sampled only at the start of an output period. A change in mid-period leaves the current period's high and low times unchanged, and `clk_out` never shows a pulse narrower than half an input period, including when entering or leaving bypass.
- R7: `rise_strobe` is high for the one `clk_in` cycle that starts at each rising edge of `clk_out`, and it stays high continuously in bypass.
- R8: Every rising edge of `clk_out` coincides with a rising edge of `clk_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prescale | input | 8 | Divide value N; ratio is 1 + N |
| clk_out | output | 1 | Divided clock, 50% duty |
| rise_strobe | output | 1 | One-cycle pulse at each output rising edge |

## Verification
The assertions assume that `clk_in` runs freely with an even duty cycle, that `prescale` is stable around each rising edge of `clk_in`, and that reset is released away from a rising edge. The bench drives `prescale` and `rst_n` only on falling edges of `clk_in`. It changes `prescale` at arbitrary points inside output periods, not only at period boundaries, so that the sampling rule is exercised.

// File: rtl/hdd_pkg.sv
`timescale 1ns/1ps
package hdd_pkg;
  typedef enum logic [1:0] {
    RATIO_ONE  = 2'd0,
    RATIO_EVEN = 2'd1,
    RATIO_ODD  = 2'd2
  } ratio_kind_e;

  // D = 1 + N: N zero gives bypass, odd N gives an even ratio
  function automatic ratio_kind_e classify(input logic is_zero, input logic lsb);
    if (is_zero) return RATIO_ONE;
    return lsb ? RATIO_EVEN : RATIO_ODD;
  endfunction
endpackage

// File: rtl/hdd_sequencer.sv
`timescale 1ns/1ps
module hdd_sequencer #(
  parameter int W = 8
) (
  input  logic         clk_in,
  input  logic         rst_n,
  input  logic [W-1:0] prescale,
  output logic [W-1:0] cnt,
  output logic [W-1:0] n_cur,
  output logic         wrap,
  output logic         byp_req,
  output logic         rise_strobe
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic presc_zero;
  assign presc_zero = (prescale == '0);
  assign wrap       = (cnt == '0);

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      cnt         <= '0;
      n_cur       <= '0;
      byp_req     <= 1'b0;
      rise_strobe <= 1'b0;
    end else begin
      rise_strobe <= wrap;
      if (wrap) begin
        n_cur   <= prescale;
        byp_req <= presc_zero;
        cnt     <= presc_zero ? '0 : ONE;
      end else begin
        cnt <= (cnt == n_cur) ? '0 : cnt + ONE;
      end
    end
  end
endmodule

// File: rtl/hdd_rise_path.sv
`timescale 1ns/1ps
module hdd_rise_path
  import hdd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_in,
  input  logic         rst_n,
  input  logic         wrap,
  input  logic [W-1:0] prescale,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] n_cur,
  output logic         r_tog,
  output logic         fall_req
);
  logic [W:0]  half_w;
  logic        at_half;
  ratio_kind_e kind;

  // (N+1)>>1 is D/2 for even D and (D-1)/2 for odd D
  assign half_w  = ({1'b0, n_cur} + {{W{1'b0}}, 1'b1}) >> 1;
  assign at_half = ({1'b0, cnt} == half_w);
  assign kind    = classify(n_cur == '0, n_cur[0]);

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      r_tog    <= 1'b0;
      fall_req <= 1'b0;
    end else begin
      if (wrap) begin
        if (prescale != '0) r_tog <= ~r_tog;
        fall_req <= 1'b0;
      end else begin
        if (kind == RATIO_EVEN && at_half) r_tog <= ~r_tog;
        fall_req <= (kind == RATIO_ODD) && at_half;
      end
    end
  end
endmodule

// File: rtl/hdd_fall_path.sv
`timescale 1ns/1ps
module hdd_fall_path (
  input  logic clk_in,
  input  logic rst_n,
  input  logic fall_req,
  input  logic byp_req,
  output logic f_tog,
  output logic byp_neg
);
  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      f_tog   <= 1'b0;
      byp_neg <= 1'b0;
    end else begin
      if (fall_req) f_tog <= ~f_tog;
      byp_neg <= byp_req;
    end
  end
endmodule

// File: rtl/hdd_out_sel.sv
`timescale 1ns/1ps
module hdd_out_sel (
  input  logic clk_in,
  input  logic byp_req,
  input  logic byp_neg,
  input  logic r_tog,
  input  logic f_tog,
  output logic clk_out
);
  logic byp_eff;
  logic div_clk;

  // select widens on a rising edge, narrows only after a falling edge
  assign byp_eff = byp_req | byp_neg;
  assign div_clk = r_tog ^ f_tog;
  assign clk_out = (byp_eff & clk_in) | div_clk;
endmodule

// File: rtl/hdd_divider.sv
`timescale 1ns/1ps
module hdd_divider #(
  parameter int W = 8
) (
  input  logic         clk_in,
  input  logic         rst_n,
  input  logic [W-1:0] prescale,
  output logic         clk_out,
  output logic         rise_strobe
);
  logic [W-1:0] cnt;
  logic [W-1:0] n_cur;
  logic         wrap;
  logic         byp_req;
  logic         r_tog;
  logic         fall_req;
  logic         f_tog;
  logic         byp_neg;

  hdd_sequencer #(.W(W)) u_seq (
    .clk_in(clk_in), .rst_n(rst_n), .prescale(prescale),
    .cnt(cnt), .n_cur(n_cur), .wrap(wrap), .byp_req(byp_req),
    .rise_strobe(rise_strobe)
  );

  hdd_rise_path #(.W(W)) u_rise (
    .clk_in(clk_in), .rst_n(rst_n), .wrap(wrap), .prescale(prescale),
    .cnt(cnt), .n_cur(n_cur), .r_tog(r_tog), .fall_req(fall_req)
  );

  hdd_fall_path u_fall (
    .clk_in(clk_in), .rst_n(rst_n), .fall_req(fall_req), .byp_req(byp_req),
    .f_tog(f_tog), .byp_neg(byp_neg)
  );

  hdd_out_sel u_sel (
    .clk_in(clk_in), .byp_req(byp_req), .byp_neg(byp_neg),
    .r_tog(r_tog), .f_tog(f_tog), .clk_out(clk_out)
  );
endmodule

// File: rtl/hdd_divider_chk.sv
`timescale 1ns/1ps
module hdd_divider_chk #(
  parameter int W = 8
) (
  input logic         clk_in,
  input logic         rst_n,
  input logic [W-1:0] cnt,
  input logic [W-1:0] n_cur,
  input logic         wrap,
  input logic         byp_req,
  input logic         fall_req,
  input logic         clk_out,
  input logic         rise_strobe
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk_in)
    !rst_n |-> (!clk_out && !rise_strobe));

  // R2
  cnt_bound_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    cnt <= n_cur);

  // R2
  low_before_rise_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (wrap && !byp_req) |-> !clk_out);

  // R6
  ratio_hold_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    !wrap |=> $stable(n_cur));

  // R4
  odd_fall_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    fall_req |-> (n_cur != '0 && !n_cur[0]));

  // R5
  bypass_zero_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    byp_req |-> (n_cur == '0));

  // R7
  strobe_single_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (rise_strobe && !wrap) |=> !rise_strobe);
endmodule

bind hdd_divider hdd_divider_chk #(.W(W)) u_chk (
  .clk_in(clk_in), .rst_n(rst_n), .cnt(cnt), .n_cur(n_cur), .wrap(wrap),
  .byp_req(byp_req), .fall_req(fall_req), .clk_out(clk_out),
  .rise_strobe(rise_strobe)
);

// File: tb/hdd_divider_test.sv
`timescale 1ns/1ps
module hdd_divider_test;
  localparam real TP = 5.0;

  logic       clk_in = 1'b0;
  logic       rst_n  = 1'b0;
  logic [7:0] prescale = 8'd4;
  logic       clk_out;
  logic       rise_strobe;

  int  n_checks = 0;
  int  n_errors = 0;
  real last_edge = -1.0;
  real min_w = 1.0e9;

  always #(TP/2.0) clk_in = ~clk_in;

  hdd_divider uut (
    .clk_in(clk_in), .rst_n(rst_n), .prescale(prescale),
    .clk_out(clk_out), .rise_strobe(rise_strobe)
  );

  always @(clk_out) begin
    if (rst_n && last_edge >= 0.0 && ($realtime - last_edge) < min_w)
      min_w = $realtime - last_edge;
    last_edge = $realtime;
  end

  function automatic real exp_period(input int n);
    return (n + 1) * TP;
  endfunction

  function automatic real exp_high(input int n);
    return (n + 1) * TP / 2.0;
  endfunction

  task automatic check(input bit ok, input string req, input real act, input real exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0.3f expected=%0.3f", req, act, exp);
    end
  endtask

  function automatic bit near(input real a, input real b);
    return (a - b < 0.01) && (b - a < 0.01);
  endfunction

  task automatic finish_run();
    check(min_w >= TP/2.0 - 0.01, "R6 narrowest pulse", min_w, TP/2.0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  // settle on the new ratio, then measure one full output period
  task automatic measure(input int n);
    real t0, t1, t2;
    string tag;
    tag = (n == 0) ? "R5" : ((n % 2) ? "R3" : "R4");
    repeat (2) @(posedge clk_out);
    @(posedge clk_out);
    t0 = $realtime;
    check(clk_in === 1'b1, "R8 rise aligned", real'(clk_in), 1.0);
    @(negedge clk_out);
    t1 = $realtime;
    @(posedge clk_out);
    t2 = $realtime;
    check(near(t2 - t0, exp_period(n)), "R2 period", t2 - t0, exp_period(n));
    check(near(t1 - t0, exp_high(n)), {tag, " high time"}, t1 - t0, exp_high(n));
    @(negedge clk_in);
    check(rise_strobe === 1'b1, "R7 strobe at rise", real'(rise_strobe), 1.0);
    @(negedge clk_in);
    check(rise_strobe === (n == 0), "R7 strobe width", real'(rise_strobe),
          real'(n == 0));
  endtask

  initial begin
    repeat (150000) @(posedge clk_in);
    n_errors++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end

  initial begin
    int unsigned seed;
    real t_rel, t0, t1, t2, t3, t4;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk_in);
    // R1 reset state
    check(clk_out === 1'b0, "R1 clk_out in reset", real'(clk_out), 0.0);
    check(rise_strobe === 1'b0, "R1 strobe in reset", real'(rise_strobe), 0.0);
    rst_n = 1'b1;
    t_rel = $realtime;
    @(posedge clk_out);
    check(near($realtime - t_rel, TP/2.0), "R1 first rise", $realtime - t_rel, TP/2.0);
    measure(4);

    // directed corners
    prescale = 8'd0;   measure(0);
    prescale = 8'd1;   measure(1);
    prescale = 8'd2;   measure(2);
    prescale = 8'd0;   measure(0);
    prescale = 8'd255; measure(255);
    prescale = 8'd254; measure(254);

    // R6 mid-period change
    @(negedge clk_in); prescale = 8'd9; measure(9);
    @(posedge clk_out); t0 = $realtime;
    repeat (2) @(negedge clk_in);
    prescale = 8'd3;
    @(negedge clk_out); t1 = $realtime;
    @(posedge clk_out); t2 = $realtime;
    check(near(t1 - t0, exp_high(9)), "R6 old high kept", t1 - t0, exp_high(9));
    check(near(t2 - t0, exp_period(9)), "R6 old period kept", t2 - t0, exp_period(9));
    @(negedge clk_out); t3 = $realtime;
    @(posedge clk_out); t4 = $realtime;
    check(near(t3 - t2, exp_high(3)), "R6 new high", t3 - t2, exp_high(3));
    check(near(t4 - t2, exp_period(3)), "R6 new period", t4 - t2, exp_period(3));

    // constrained random ratios, changed at random points in the period
    for (int i = 0; i < 14; i++) begin
      int n;
      n = (i % 4 == 3) ? 0 : int'($urandom_range(1, 255));
      repeat ($urandom_range(0, 5)) @(negedge clk_in);
      @(negedge clk_in);
      prescale = 8'(n);
      measure(n);
    end
    finish_run();
  end
endmodule